// File: doc/BRIEF.md
# Tagged Two-Bit Branch Predictor with Target Cache

This block sits in the fetch stage of a pipelined processor. Every cycle it takes the fetch address and looks it up in a direct-mapped table. Each slot of the table holds three things: a two-bit confidence counter, a tag taken from the upper address bits, and the target address the branch went to the last time it was taken. When the lookup hits and the counter leans toward taken, the block returns the cached target as the next fetch address in the same cycle. No target arithmetic is needed. In every other case the next fetch address is the sequential address.

A later pipeline stage resolves each branch. It sends back the branch address, the real outcome, the real target, and the prediction that was made for that branch at fetch. The block trains the counter of the slot selected by the branch address. On a taken branch it also writes the tag and the target into that slot. If the prediction was wrong, it raises a flush request in the same cycle and gives the address fetch must restart from. Flushing the pipeline itself is done elsewhere.

Top module: `fetch_bpred`

## Requirements
- R1: After reset every slot is empty and its counter holds weak-not-taken. Any fetch address then predicts not taken, with `next_pc` = `fetch_pc` + 4.
- R2: The counter is encoded 00 strong-not-taken, 01 weak-not-taken, 10 weak-taken, 11 strong-taken. A taken outcome moves it one step toward 11 and a not-taken outcome moves it one step toward 00, saturating at both ends. The prediction direction therefore changes only after two wrong outcomes in a row, starting from a strong state.
- R3: `pred_taken` is 1 only when the lookup hits and the counter is 10 or 11. A lookup that misses predicts not taken.
- R4: `next_pc` equals `pred_target` when `pred_taken` is 1, and `fetch_pc` + 4 otherwise.
- R5: A resolved taken branch writes its tag, its target and the valid bit into its slot, replacing any older target. A resolved not-taken branch leaves the tag and target unchanged.
- R6: Every resolve trains the counter of the slot selected by `res_pc` bits [7:2]. This happens whether the tag matched or not.
- R7: The slot index is address bits [7:2] and the tag is bits [31:8]. A fetch whose tag differs from the stored tag misses, even when the slot is valid.
- R8: `flush_req` is 1 in the cycle of a resolve when the direction in `res_pred_taken` differs from `res_taken`. It is also 1 when both are taken but `res_pred_target` differs from `res_target`. It is 0 in every other cycle.
- R9: While `flush_req` is 1, `redirect_pc` is `res_target` for a taken branch and `res_pc` + 4 for a not-taken branch.
- R10: When a lookup and a resolve select the same slot in the same cycle, the lookup returns the slot contents from before the update.

Note on R2 and R3: the counter encodings listed in R2 are the bit values that R3 relies on when it refers to "10 or 11".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_taken | output | 1 | Predict-taken flag for `fetch_pc` |
| pred_target | output | 32 | Cached target of the selected slot |
| next_pc | output | 32 | Next fetch address: cached target or fall-through |
| res_valid | input | 1 | A branch is being resolved this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome of the branch |
| res_target | input | 32 | Computed target of the branch |
| res_pred_taken | input | 1 | Direction that was predicted for this branch at fetch |
| res_pred_target | input | 32 | Target that was predicted for this branch at fetch |
| flush_req | output | 1 | Mispredict: flush the pipeline and redirect fetch |
| redirect_pc | output | 32 | Correct restart address while `flush_req` is 1 |

## Verification
The hardest situations to reach are those where two different branch addresses share one slot. In one case a branch that does not own the slot's tag trains that slot's counter. In another, a lookup and a resolve of the same slot fall in the same cycle. Both require a resolve address and a fetch address chosen to collide in bits [7:2] but differ in bits [31:8]. The stimulus therefore draws its addresses from a small pool of four indices and two tags, so collisions, tag replacements and same-cycle conflicts happen often. Directed steps first walk one slot through every counter transition, then exercise a target that a taken branch reports with a wrong cached target.

// File: rtl/fetch_bpred_pkg.sv
package fetch_bpred_pkg;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'b00,
      CTR_WEAK_NT   = 2'b01,
      CTR_WEAK_T    = 2'b10,
      CTR_STRONG_T  = 2'b11
   } ctr_t;

   localparam ctr_t CTR_RESET = CTR_WEAK_NT;

endpackage

// File: rtl/bp_ctr_step.sv
module bp_ctr_step
   import fetch_bpred_pkg::*;
(
   input  ctr_t cur,
   input  logic taken,
   output ctr_t nxt
);

   always_comb begin
      nxt = cur;
      unique case (cur)
         CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
         CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
         CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
         CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
         default:       nxt = CTR_RESET;
      endcase
   end

endmodule

// File: rtl/bp_slot.sv
module bp_slot
   import fetch_bpred_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 24,
   parameter bit TAG_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctr_we,
   input  ctr_t              ctr_d,
   input  logic              fill_we,
   input  logic [TAG_W-1:0]  tag_d,
   input  logic [ADDR_W-1:0] tgt_d,
   output ctr_t              ctr_q,
   output logic              vld_q,
   output logic [TAG_W-1:0]  tag_q,
   output logic [ADDR_W-1:0] tgt_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctr_q <= CTR_RESET;
         vld_q <= 1'b0;
         tgt_q <= '0;
      end else begin
         if (ctr_we)  ctr_q <= ctr_d;
         if (fill_we) begin
            vld_q <= 1'b1;
            tgt_q <= tgt_d;
         end
      end
   end

   generate
      if (TAG_EN) begin : g_tag
         logic [TAG_W-1:0] tag_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       tag_r <= '0;
            else if (fill_we) tag_r <= tag_d;
         end
         assign tag_q = tag_r;
      end else begin : g_notag
         assign tag_q = '0;
      end
   endgenerate

endmodule

// File: rtl/bp_table.sv
module bp_table
   import fetch_bpred_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 6,
   parameter int TAG_W  = 24,
   parameter bit TAG_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lk_idx,
   output ctr_t              lk_ctr,
   output logic              lk_vld,
   output logic [TAG_W-1:0]  lk_tag,
   output logic [ADDR_W-1:0] lk_tgt,
   input  logic [IDX_W-1:0]  up_idx,
   output ctr_t              up_ctr,
   input  logic              up_we,
   input  ctr_t              up_ctr_d,
   input  logic              fill_we,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [ADDR_W-1:0] fill_tgt
);

   localparam int ENTRIES = 1 << IDX_W;

   ctr_t              s_ctr [ENTRIES];
   logic              s_vld [ENTRIES];
   logic [TAG_W-1:0]  s_tag [ENTRIES];
   logic [ADDR_W-1:0] s_tgt [ENTRIES];

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
         logic sel;
         assign sel = (up_idx == IDX_W'(e));
         bp_slot #(
            .ADDR_W (ADDR_W),
            .TAG_W  (TAG_W),
            .TAG_EN (TAG_EN)
         ) i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctr_we  (up_we && sel),
            .ctr_d   (up_ctr_d),
            .fill_we (fill_we && sel),
            .tag_d   (fill_tag),
            .tgt_d   (fill_tgt),
            .ctr_q   (s_ctr[e]),
            .vld_q   (s_vld[e]),
            .tag_q   (s_tag[e]),
            .tgt_q   (s_tgt[e])
         );
      end
   endgenerate

   assign lk_ctr = s_ctr[lk_idx];
   assign lk_vld = s_vld[lk_idx];
   assign lk_tag = s_tag[lk_idx];
   assign lk_tgt = s_tgt[lk_idx];
   assign up_ctr = s_ctr[up_idx];

endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_pc,
   input  logic              res_taken,
   input  logic [ADDR_W-1:0] res_target,
   input  logic              res_pred_taken,
   input  logic [ADDR_W-1:0] res_pred_target,
   output logic              flush_req,
   output logic [ADDR_W-1:0] redirect_pc
);

   logic dir_wrong;
   logic tgt_wrong;

   always_comb begin
      dir_wrong   = (res_taken != res_pred_taken);
      tgt_wrong   = res_taken && res_pred_taken && (res_pred_target != res_target);
      flush_req   = res_valid && (dir_wrong || tgt_wrong);
      redirect_pc = res_taken ? res_target : (res_pc + ADDR_W'(STEP));
   end

endmodule

// File: rtl/fetch_bpred.sv
module fetch_bpred
   import fetch_bpred_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int IDX_W       = 6,
   parameter int INSTR_ALIGN = 2,
   parameter bit TAG_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] fetch_pc,
   output logic              pred_taken,
   output logic [ADDR_W-1:0] pred_target,
   output logic [ADDR_W-1:0] next_pc,
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_pc,
   input  logic              res_taken,
   input  logic [ADDR_W-1:0] res_target,
   input  logic              res_pred_taken,
   input  logic [ADDR_W-1:0] res_pred_target,
   output logic              flush_req,
   output logic [ADDR_W-1:0] redirect_pc
);

   localparam int TAG_W = ADDR_W - IDX_W - INSTR_ALIGN;
   localparam int STEP  = 1 << INSTR_ALIGN;

   initial begin
      assert (IDX_W >= 1 && IDX_W <= 10)
         else $error("fetch_bpred: IDX_W must lie in 1..10");
      assert (INSTR_ALIGN >= 0 && INSTR_ALIGN <= 3)
         else $error("fetch_bpred: INSTR_ALIGN must lie in 0..3");
      assert (TAG_W >= 1)
         else $error("fetch_bpred: address too narrow for index and tag");
   end

   logic [IDX_W-1:0]  lk_idx, up_idx;
   logic [TAG_W-1:0]  lk_pc_tag, up_pc_tag;
   ctr_t              lk_ctr, up_ctr, up_ctr_nxt;
   logic              lk_vld;
   logic [TAG_W-1:0]  lk_tag;
   logic [ADDR_W-1:0] lk_tgt;
   logic              lk_hit;

   assign lk_idx    = fetch_pc[INSTR_ALIGN +: IDX_W];
   assign up_idx    = res_pc[INSTR_ALIGN +: IDX_W];
   assign lk_pc_tag = fetch_pc[ADDR_W-1 -: TAG_W];
   assign up_pc_tag = res_pc[ADDR_W-1 -: TAG_W];

   bp_table #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .TAG_EN (TAG_EN)
   ) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_idx   (lk_idx),
      .lk_ctr   (lk_ctr),
      .lk_vld   (lk_vld),
      .lk_tag   (lk_tag),
      .lk_tgt   (lk_tgt),
      .up_idx   (up_idx),
      .up_ctr   (up_ctr),
      .up_we    (res_valid),
      .up_ctr_d (up_ctr_nxt),
      .fill_we  (res_valid && res_taken),
      .fill_tag (up_pc_tag),
      .fill_tgt (res_target)
   );

   bp_ctr_step i_step (
      .cur   (up_ctr),
      .taken (res_taken),
      .nxt   (up_ctr_nxt)
   );

   generate
      if (TAG_EN) begin : g_hit_tag
         assign lk_hit = lk_vld && (lk_tag == lk_pc_tag);
      end else begin : g_hit_notag
         assign lk_hit = lk_vld;
      end
   endgenerate

   assign pred_taken  = lk_hit && ((lk_ctr == CTR_WEAK_T) || (lk_ctr == CTR_STRONG_T));
   assign pred_target = lk_tgt;
   assign next_pc     = pred_taken ? lk_tgt : (fetch_pc + ADDR_W'(STEP));

   bp_resolve #(
      .ADDR_W (ADDR_W),
      .STEP   (STEP)
   ) i_resolve (
      .res_valid       (res_valid),
      .res_pc          (res_pc),
      .res_taken       (res_taken),
      .res_target      (res_target),
      .res_pred_taken  (res_pred_taken),
      .res_pred_target (res_pred_target),
      .flush_req       (flush_req),
      .redirect_pc     (redirect_pc)
   );

endmodule

// File: rtl/fetch_bpred_chk.sv
module fetch_bpred_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] fetch_pc,
   input logic              pred_taken,
   input logic [ADDR_W-1:0] pred_target,
   input logic [ADDR_W-1:0] next_pc,
   input logic              res_valid,
   input logic [ADDR_W-1:0] res_pc,
   input logic              res_taken,
   input logic [ADDR_W-1:0] res_target,
   input logic              res_pred_taken,
   input logic [ADDR_W-1:0] res_pred_target,
   input logic              flush_req,
   input logic [ADDR_W-1:0] redirect_pc,
   input logic              lk_hit
);

   AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> !pred_taken); // R3

   AST_NEXT_IS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> next_pc == pred_target); // R4

   AST_NEXT_IS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> next_pc == fetch_pc + ADDR_W'(4)); // R4

   AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(res_valid && res_taken) && fetch_pc == $past(res_pc))
         |-> (lk_hit && pred_target == $past(res_target))); // R5

   AST_DIR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_taken != res_pred_taken) |-> flush_req); // R8

   AST_TGT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_taken && res_pred_taken && res_pred_target != res_target)
         |-> (flush_req && redirect_pc == res_target)); // R8

   AST_FLUSH_NEEDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> res_valid); // R8

   AST_REDIRECT_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && !res_taken) |-> redirect_pc == res_pc + ADDR_W'(4)); // R9

endmodule

bind fetch_bpred fetch_bpred_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .fetch_pc        (fetch_pc),
   .pred_taken      (pred_taken),
   .pred_target     (pred_target),
   .next_pc         (next_pc),
   .res_valid       (res_valid),
   .res_pc          (res_pc),
   .res_taken       (res_taken),
   .res_target      (res_target),
   .res_pred_taken  (res_pred_taken),
   .res_pred_target (res_pred_target),
   .flush_req       (flush_req),
   .redirect_pc     (redirect_pc),
   .lk_hit          (lk_hit)
);

// File: tb/test_fetch_bpred.sv
`timescale 1ns/1ps
module test_fetch_bpred;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        pred_taken;
   logic [31:0] pred_target;
   logic [31:0] next_pc;
   logic        res_valid = 1'b0;
   logic [31:0] res_pc = '0;
   logic        res_taken = 1'b0;
   logic [31:0] res_target = '0;
   logic        res_pred_taken = 1'b0;
   logic [31:0] res_pred_target = '0;
   logic        flush_req;
   logic [31:0] redirect_pc;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   fetch_bpred i_fetch_bpred (
      .clk             (clk),
      .rst_n           (rst_n),
      .fetch_pc        (fetch_pc),
      .pred_taken      (pred_taken),
      .pred_target     (pred_target),
      .next_pc         (next_pc),
      .res_valid       (res_valid),
      .res_pc          (res_pc),
      .res_taken       (res_taken),
      .res_target      (res_target),
      .res_pred_taken  (res_pred_taken),
      .res_pred_target (res_pred_target),
      .flush_req       (flush_req),
      .redirect_pc     (redirect_pc)
   );

   // behavioural reference: saturating integer counter per slot
   int          m_ctr [64];
   bit          m_vld [64];
   logic [23:0] m_tag [64];
   logic [31:0] m_tgt [64];

   function automatic bit m_hit(logic [31:0] pc);
      return m_vld[pc[7:2]] && (m_tag[pc[7:2]] == pc[31:8]);
   endfunction

   function automatic bit m_pred(logic [31:0] pc);
      return m_hit(pc) && (m_ctr[pc[7:2]] >= 2);
   endfunction

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h at %0t", what, act, exp, $time);
      end
   endtask

   task automatic drv(logic [31:0] fpc, logic rv, logic [31:0] rpc, logic rtk,
                      logic [31:0] rtgt, logic rptk, logic [31:0] rptgt);
      fetch_pc        = fpc;
      res_valid       = rv;
      res_pc          = rpc;
      res_taken       = rtk;
      res_target      = rtgt;
      res_pred_taken  = rptk;
      res_pred_target = rptgt;
      #2;
   endtask

   // compare against the model, clock once, then advance the model
   task automatic tick();
      bit          ept;
      bit          efl;
      logic [31:0] ered;
      int          ix;
      ept = m_pred(fetch_pc);
      chk("R3 pred_taken", {31'b0, pred_taken}, {31'b0, ept});
      chk("R4 next_pc", next_pc, ept ? m_tgt[fetch_pc[7:2]] : fetch_pc + 32'd4);
      if (ept) chk("R5 pred_target", pred_target, m_tgt[fetch_pc[7:2]]);
      efl  = res_valid && ((res_taken != res_pred_taken) ||
             (res_taken && res_pred_taken && res_pred_target != res_target));
      ered = res_taken ? res_target : res_pc + 32'd4;
      chk("R8 flush_req", {31'b0, flush_req}, {31'b0, efl});
      if (efl) chk("R9 redirect_pc", redirect_pc, ered);
      @(posedge clk);
      if (res_valid) begin
         ix = int'(res_pc[7:2]);
         if (res_taken) begin
            if (m_ctr[ix] < 3) m_ctr[ix]++;
            m_vld[ix] = 1'b1;
            m_tag[ix] = res_pc[31:8];
            m_tgt[ix] = res_target;
         end else if (m_ctr[ix] > 0) begin
            m_ctr[ix]--;
         end
      end
      @(negedge clk);
   endtask

   localparam logic [31:0] PA = 32'h0000_1000; // slot 0, tag 0x10
   localparam logic [31:0] PB = 32'h0000_1100; // slot 0, tag 0x11
   localparam logic [31:0] PC = 32'h0000_1004; // slot 1, tag 0x10
   localparam logic [31:0] PD = 32'h0000_1104; // slot 1, tag 0x11
   localparam logic [31:0] T1 = 32'h0000_4000;
   localparam logic [31:0] T3 = 32'h0000_6000;
   localparam logic [31:0] T5 = 32'h0000_7a40;

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         m_ctr[i] = 1; m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: empty table after reset
      for (int k = 0; k < 4; k++) begin
         drv(PA + 32'(k * 68), 0, 0, 0, 0, 0, 0);
         chk("R1 reset pred_taken", {31'b0, pred_taken}, 32'd0);
         chk("R1 reset next_pc", next_pc, PA + 32'(k * 68) + 32'd4);
         tick();
      end

      // first taken resolve, same-cycle lookup of the same slot
      drv(PA, 1, PA, 1, T1, 0, 0);
      chk("R10 lookup sees old slot", {31'b0, pred_taken}, 32'd0);
      chk("R8 direction flush", {31'b0, flush_req}, 32'd1);
      chk("R9 redirect to target", redirect_pc, T1);
      tick();                                   // slot0: 10, tag A, T1

      drv(PA, 0, 0, 0, 0, 0, 0);
      chk("R6 miss trained counter", {31'b0, pred_taken}, 32'd1);
      chk("R5 target installed", pred_target, T1);
      chk("R4 next_pc from cache", next_pc, T1);
      tick();

      drv(PB, 1, PA, 1, T1, 1, T1);
      chk("R7 alias misses", {31'b0, pred_taken}, 32'd0);
      chk("R7 alias falls through", next_pc, PB + 32'd4);
      chk("R8 correct no flush", {31'b0, flush_req}, 32'd0);
      tick();                                   // slot0: 11

      drv(PA, 1, PA, 0, 0, 1, T1);
      chk("R9 redirect fall-through", redirect_pc, PA + 32'd4);
      tick();                                   // slot0: 10
      drv(PA, 0, 0, 0, 0, 0, 0);
      chk("R2 one wrong keeps taken", {31'b0, pred_taken}, 32'd1);
      tick();
      drv(PA, 1, PA, 0, 0, 1, T1);
      tick();                                   // slot0: 01
      drv(PA, 0, 0, 0, 0, 0, 0);
      chk("R2 two wrong flips", {31'b0, pred_taken}, 32'd0);
      tick();
      drv(PA, 1, PA, 1, T1, 0, T1);
      tick();                                   // slot0: 10
      drv(PA, 0, 0, 0, 0, 0, 0);
      chk("R2 weak not-taken back to taken", {31'b0, pred_taken}, 32'd1);
      tick();

      // slot 1: alias branch trains counter without replacing tag/target
      drv(PC, 1, PC, 1, T3, 0, 0);    tick();   // 10
      drv(PC, 1, PC, 1, T3, 1, T3);   tick();   // 11
      drv(PC, 1, PD, 0, 0, 0, 0);     tick();   // 10, tag C kept
      drv(PC, 0, 0, 0, 0, 0, 0);
      chk("R5 not-taken keeps target", pred_target, T3);
      chk("R6 alias trained to weak taken", {31'b0, pred_taken}, 32'd1);
      tick();
      drv(PD, 1, PD, 0, 0, 0, 0);     tick();   // 01
      drv(PC, 0, 0, 0, 0, 0, 0);
      chk("R6 alias trained to weak not-taken", {31'b0, pred_taken}, 32'd0);
      tick();
      drv(PC, 1, PC, 1, T3, 0, 0);    tick();   // 10

      // wrong cached target on a correctly predicted direction
      drv(PC, 1, PC, 1, T5, 1, T3);
      chk("R8 target mismatch flush", {31'b0, flush_req}, 32'd1);
      chk("R9 redirect new target", redirect_pc, T5);
      tick();
      drv(PC, 0, 0, 0, 0, 0, 0);
      chk("R5 target replaced", pred_target, T5);
      tick();

      // colliding traffic against the model
      for (int n = 0; n < 1500; n++) begin
         logic [31:0] fp, rp, tg, ptg;
         bit          rv, tk, ptk;
         fp  = 32'h1000 + 32'($urandom_range(0, 1) * 256) + 32'($urandom_range(0, 3) * 4);
         rp  = 32'h1000 + 32'($urandom_range(0, 1) * 256) + 32'($urandom_range(0, 3) * 4);
         if ($urandom_range(0, 3) == 0) rp = fp;
         rv  = ($urandom_range(0, 3) != 0);
         tk  = ($urandom_range(0, 2) != 0);
         tg  = 32'h8000 + 32'($urandom_range(0, 3) * 64);
         ptk = m_pred(rp);
         ptg = m_tgt[rp[7:2]];
         if ($urandom_range(0, 7) == 0) ptk = ~ptk;
         if ($urandom_range(0, 7) == 0) ptg = ptg ^ 32'h40;
         drv(fp, rv, rp, tk, tg, ptk, ptg);
         tick();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule